// File: doc/BRIEF.md
# Nibble Subtract and Compare Execution Unit

This unit carries out one instruction group of a small 4-bit processor datapath. It handles three operations: a plain subtract, a subtract that also takes away the incoming carry, and a compare. The unit owns two 4-bit accumulators (A and B) and two index registers (X and Y). It also owns the carry, zero and extension flags. An operand can come from an accumulator, from a 4-bit immediate, or from data memory. Memory is reached indirectly through X or Y, and the index can optionally be incremented after the access.

A 13-bit instruction word is presented with `instr_valid`. When the destination is a register, the instruction finishes in the cycle it is accepted. When the destination is memory, the unit uses a second cycle. In that cycle it writes the difference back to the address it read from. The memory read is combinational, so `mem_rdata` must reflect `mem_addr` within the same cycle. Writes take effect on the clock edge while `mem_we` is high.

Encodings outside the defined set are flagged on `illegal` and leave everything unchanged. A separate output warns when an immediate form is accepted while the extension flag is set. The unit does not widen such an immediate; it uses the 4-bit field as is.

Top module: `nsc_sub_unit`

## Requirements
- R1: After synchronous reset: A=0, B=0, X=0, Y=0x80, C=0, Z=0, E=0; busy and mem_we are low.
- R2: Bits 12..7 choose the operation: 110000 is subtract, 110001 is subtract-with-carry, and 111100 is compare. Any other prefix raises `illegal` in the accepting cycle.
- R3: Register-destination forms finish in one cycle. The result is destination minus source. Immediate forms use bits 6..4 = 100 for A and 101 for B, with the immediate in bits 3..0. Register-to-register forms use bits 6..4 = 111, with bit 2 as the destination (0=A, 1=B) and bit 1 as the source (0=A, 1=B). For subtract and subtract-with-carry, bit 3 must be 0. For compare, bit 0 must be 0.
- R4: The memory-source, register-destination form is bits 6..3 = 1100. Bit 2 selects the destination (0=A, 1=B). Bit 1 selects the index (0=X, 1=Y), and bit 0 requests a post-increment. `mem_addr` shows the chosen index in the same cycle.
- R5: Memory-destination forms take two cycles. Immediate-source forms use bit 6 = 0, bit 5 as the index select and bit 4 as the post-increment. Register-source forms use bits 6..3 = 1101, bit 2 as the source (0=A, 1=B), bit 1 as the index select and bit 0 as the post-increment. In the second cycle, busy and mem_we are high, the address is unchanged and the difference is written.
- R6: Compare updates only the flags and never changes A, B or memory.
- R7: C is set when the 4-bit subtraction borrows, and Z is set when the 4-bit difference is zero. Every accepted legal instruction clears E.
- R8: Subtract-with-carry also subtracts the current C. Plain subtract ignores C.
- R9: A post-increment adds one to the index used, after the access, wrapping modulo 2^IDX_W.
- R10: An undefined encoding within the three prefixes raises `illegal` and writes no register, flag, index or memory. Undefined encodings are: subtract with an A destination, compare with a memory destination, a subtract or subtract-with-carry register pair with bit 3 = 1, and a compare register pair with bit 0 = 1.
- R11: `ext_imm_err` is high in the accepting cycle of a legal immediate form while E=1. The instruction still executes with the 4-bit immediate.
- R12: `instr_valid` is ignored while busy. It produces no `illegal` and no state change.
- R13: `ext_set` sets E in a cycle where no instruction completes. Completion wins when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 13 | Instruction word |
| ext_set | input | 1 | Request to set the extension flag |
| mem_rdata | input | 4 | Combinational read data for mem_addr |
| mem_addr | output | IDX_W | Data memory address |
| mem_we | output | 1 | Write enable for the write-back cycle |
| mem_wdata | output | 4 | Write-back data |
| busy | output | 1 | Write-back cycle in progress |
| illegal | output | 1 | Undefined encoding accepted this cycle |
| ext_imm_err | output | 1 | Immediate form accepted while E set |
| acc_a | output | 4 | Accumulator A |
| acc_b | output | 4 | Accumulator B |
| idx_x | output | IDX_W | Index register X |
| idx_y | output | IDX_W | Index register Y |
| flag_c | output | 1 | Carry (borrow) flag |
| flag_z | output | 1 | Zero flag |
| flag_e | output | 1 | Extension flag |

## Verification
The assertions assume that `mem_rdata` settles within the cycle for whatever address is shown. They also assume that a write-back cycle starts only after an instruction was offered. The bench meets the first assumption with a combinational array read. It meets the second by offering instructions only from idle cycles, while sometimes pushing a random word into the write-back cycle to exercise R12. `ext_set` is pulsed only in idle cycles, so the precedence rule of R13 is never needed there. The random mix draws mostly from the three prefixes, with random low bits, so legal and undefined encodings both occur often.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    localparam int INSN_W = 13;
    localparam int NIB_W  = 4;

    localparam logic [5:0] PFX_SUB = 6'b110000;
    localparam logic [5:0] PFX_SBC = 6'b110001;
    localparam logic [5:0] PFX_CMP = 6'b111100;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {OP_SUB, OP_SBC, OP_CMP, OP_NONE} op_e;
    typedef enum logic [1:0] {DST_A, DST_B, DST_MEM} dst_e;
    typedef enum logic [1:0] {SRC_A, SRC_B, SRC_IMM, SRC_MEM} src_e;

    typedef struct packed {
        logic legal;
        op_e  op;
        dst_e dst;
        src_e src;
        logic use_y;
        logic inc;
        nib_t imm;
    } uop_t;

    // Borrow in the top bit, 4-bit difference below it.
    function automatic logic [NIB_W:0] nib_sub(nib_t a, nib_t b, logic cin);
        return {1'b0, a} - {1'b0, b} - {{NIB_W{1'b0}}, cin};
    endfunction

    function automatic uop_t decode(logic [INSN_W-1:0] w);
        uop_t u;
        logic is_sub;
        logic is_cmp;
        u       = '0;
        u.op    = OP_NONE;
        u.dst   = DST_A;
        u.src   = SRC_A;
        u.imm   = w[NIB_W-1:0];
        case (w[12:7])
            PFX_SUB: u.op = OP_SUB;
            PFX_SBC: u.op = OP_SBC;
            PFX_CMP: u.op = OP_CMP;
            default: u.op = OP_NONE;
        endcase
        is_sub = (u.op == OP_SUB);
        is_cmp = (u.op == OP_CMP);
        if (u.op != OP_NONE) begin
            if (!w[6]) begin
                // immediate into memory
                u.dst   = DST_MEM;
                u.src   = SRC_IMM;
                u.use_y = w[5];
                u.inc   = w[4];
                u.legal = !is_cmp;
            end else if (!w[5]) begin
                // immediate into accumulator
                u.dst   = w[4] ? DST_B : DST_A;
                u.src   = SRC_IMM;
                u.legal = w[4] || !is_sub;
            end else if (!w[4]) begin
                u.use_y = w[1];
                u.inc   = w[0];
                if (!w[3]) begin
                    u.dst   = w[2] ? DST_B : DST_A;
                    u.src   = SRC_MEM;
                    u.legal = w[2] || !is_sub;
                end else begin
                    u.dst   = DST_MEM;
                    u.src   = w[2] ? SRC_B : SRC_A;
                    u.legal = !is_cmp;
                end
            end else begin
                u.dst = w[2] ? DST_B : DST_A;
                u.src = w[1] ? SRC_B : SRC_A;
                if (is_cmp) u.legal = !w[0];
                else        u.legal = !w[3] && (w[2] || !is_sub);
            end
        end
        if (!u.legal) u.inc = 1'b0;
        return u;
    endfunction

endpackage

// File: rtl/nsc_decode.sv
module nsc_decode
    import nsc_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output uop_t              uop
);
    always_comb uop = decode(insn);
endmodule

// File: rtl/nsc_alu.sv
module nsc_alu
    import nsc_pkg::*;
(
    input  nib_t minuend,
    input  nib_t subtrahend,
    input  logic borrow_in,
    output nib_t diff,
    output logic borrow_out,
    output logic zero
);
    logic [NIB_W:0] full;
    always_comb begin
        full       = nib_sub(minuend, subtrahend, borrow_in);
        diff       = full[NIB_W-1:0];
        borrow_out = full[NIB_W];
        zero       = (full[NIB_W-1:0] == '0);
    end
endmodule

// File: rtl/nsc_index.sv
module nsc_index #(
    parameter int               IDX_W   = 8,
    parameter logic [IDX_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= RST_VAL;
        else if (step) q <= q + IDX_W'(1);
    end
endmodule

// File: rtl/nsc_sub_unit.sv
module nsc_sub_unit
    import nsc_pkg::*;
#(
    parameter int               IDX_W = 8,
    parameter logic [IDX_W-1:0] X_RST = '0,
    parameter logic [IDX_W-1:0] Y_RST = {1'b1, {(IDX_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr,
    input  logic              ext_set,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic [IDX_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              busy,
    output logic              illegal,
    output logic              ext_imm_err,
    output logic [NIB_W-1:0]  acc_a,
    output logic [NIB_W-1:0]  acc_b,
    output logic [IDX_W-1:0]  idx_x,
    output logic [IDX_W-1:0]  idx_y,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_e
);
    localparam int N_IDX = 2;

    typedef struct packed {
        logic [IDX_W-1:0] addr;
        nib_t             res;
        logic             c;
        logic             z;
        logic             use_y;
        logic             inc;
    } wb_t;

    uop_t             uop;
    wb_t              wb_q;
    logic             busy_q;
    nib_t             acc_a_q, acc_b_q;
    logic             c_q, z_q, e_q;
    logic             accept, go, reg_commit, mem_go, wr_acc, cmp_go;
    logic [IDX_W-1:0] idx_q [N_IDX];
    logic [N_IDX-1:0] idx_step;
    logic [IDX_W-1:0] idx_cur;
    nib_t             opd_d, opd_s, alu_diff;
    logic             cin, alu_c, alu_z;

    nsc_decode u_dec (.insn(instr), .uop(uop));

    assign accept     = instr_valid && !busy_q;
    assign go         = accept && uop.legal;
    assign reg_commit = go && (uop.dst != DST_MEM);
    assign mem_go     = go && (uop.dst == DST_MEM);
    assign wr_acc     = reg_commit && (uop.op != OP_CMP);
    assign cmp_go     = go && (uop.op == OP_CMP);

    generate
        for (genvar g = 0; g < N_IDX; g++) begin : g_idx
            localparam logic SEL = 1'(g);
            assign idx_step[g] =
                (reg_commit && (uop.src == SRC_MEM) && uop.inc && (uop.use_y == SEL)) ||
                (busy_q && wb_q.inc && (wb_q.use_y == SEL));
            nsc_index #(
                .IDX_W  (IDX_W),
                .RST_VAL((g == 0) ? X_RST : Y_RST)
            ) u_idx (
                .clk (clk),
                .rst (rst),
                .step(idx_step[g]),
                .q   (idx_q[g])
            );
        end
    endgenerate

    assign idx_cur  = uop.use_y ? idx_q[1] : idx_q[0];
    assign mem_addr = busy_q ? wb_q.addr : idx_cur;

    always_comb begin
        case (uop.dst)
            DST_A:   opd_d = acc_a_q;
            DST_B:   opd_d = acc_b_q;
            default: opd_d = mem_rdata;
        endcase
        case (uop.src)
            SRC_A:   opd_s = acc_a_q;
            SRC_B:   opd_s = acc_b_q;
            SRC_IMM: opd_s = uop.imm;
            default: opd_s = mem_rdata;
        endcase
    end

    assign cin = (uop.op == OP_SBC) && c_q;

    nsc_alu u_alu (
        .minuend   (opd_d),
        .subtrahend(opd_s),
        .borrow_in (cin),
        .diff      (alu_diff),
        .borrow_out(alu_c),
        .zero      (alu_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_a_q <= '0;
            acc_b_q <= '0;
            c_q     <= 1'b0;
            z_q     <= 1'b0;
            e_q     <= 1'b0;
            busy_q  <= 1'b0;
            wb_q    <= '0;
        end else begin
            if (wr_acc && uop.dst == DST_A) acc_a_q <= alu_diff;
            if (wr_acc && uop.dst == DST_B) acc_b_q <= alu_diff;
            if (reg_commit) begin
                c_q <= alu_c;
                z_q <= alu_z;
            end else if (busy_q) begin
                c_q <= wb_q.c;
                z_q <= wb_q.z;
            end
            if (reg_commit || busy_q) e_q <= 1'b0;
            else if (ext_set)         e_q <= 1'b1;
            busy_q <= mem_go;
            if (mem_go) begin
                wb_q <= '{addr: idx_cur, res: alu_diff, c: alu_c, z: alu_z,
                          use_y: uop.use_y, inc: uop.inc};
            end
        end
    end

    assign mem_we      = busy_q;
    assign mem_wdata   = wb_q.res;
    assign busy        = busy_q;
    assign illegal     = accept && !uop.legal;
    assign ext_imm_err = go && (uop.src == SRC_IMM) && e_q;
    assign acc_a       = acc_a_q;
    assign acc_b       = acc_b_q;
    assign idx_x       = idx_q[0];
    assign idx_y       = idx_q[1];
    assign flag_c      = c_q;
    assign flag_z      = z_q;
    assign flag_e      = e_q;

endmodule

// File: rtl/nsc_sub_unit_chk.sv
module nsc_sub_unit_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_valid,
    input logic             busy,
    input logic             illegal,
    input logic             cmp_go,
    input logic [3:0]       acc_a,
    input logic [3:0]       acc_b,
    input logic [IDX_W-1:0] idx_x,
    input logic [IDX_W-1:0] idx_y,
    input logic             flag_c,
    input logic             flag_z,
    input logic             flag_e
);
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);  // R5
    AST_WB_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(instr_valid));  // R5
    AST_ILL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable(acc_a) && $stable(acc_b) && $stable(idx_x) &&
                    $stable(idx_y) && $stable(flag_c) && $stable(flag_z) && !busy);  // R10
    AST_CMP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cmp_go |=> $stable(acc_a) && $stable(acc_b) && !busy);  // R6
    AST_E_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !flag_e);  // R7
    AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx_x) |-> idx_x == IDX_W'($past(idx_x) + 1'b1));  // R9
    AST_Y_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx_y) |-> idx_y == IDX_W'($past(idx_y) + 1'b1));  // R9
endmodule

bind nsc_sub_unit nsc_sub_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_valid(instr_valid),
    .busy       (busy),
    .illegal    (illegal),
    .cmp_go     (cmp_go),
    .acc_a      (acc_a),
    .acc_b      (acc_b),
    .idx_x      (idx_x),
    .idx_y      (idx_y),
    .flag_c     (flag_c),
    .flag_z     (flag_z),
    .flag_e     (flag_e)
);

// File: tb/sim_nsc_sub_unit.sv
`timescale 1ns/1ps
module sim_nsc_sub_unit;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic [12:0]   instr = '0;
    logic          ext_set = 1'b0;
    logic [3:0]    mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [3:0]    mem_wdata;
    logic          busy, illegal, ext_imm_err;
    logic [3:0]    acc_a, acc_b;
    logic [AW-1:0] idx_x, idx_y;
    logic          flag_c, flag_z, flag_e;

    always #2 clk = ~clk;

    nsc_sub_unit #(.IDX_W(AW)) u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .ext_set(ext_set), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .illegal(illegal),
        .ext_imm_err(ext_imm_err), .acc_a(acc_a), .acc_b(acc_b),
        .idx_x(idx_x), .idx_y(idx_y), .flag_c(flag_c), .flag_z(flag_z),
        .flag_e(flag_e)
    );

    logic [3:0] ram [2**AW];
    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // reference state
    logic [3:0]    ma, mb;
    logic [AW-1:0] mx, my;
    logic          mc, mz, me;
    // per-instruction expectations
    bit            e_ill, e_two, e_ext;
    logic [AW-1:0] e_addr;
    logic [3:0]    e_wd;
    string         e_tag;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [26:0] dut_state();
        return {acc_a, acc_b, idx_x, idx_y, flag_c, flag_z, flag_e};
    endfunction

    function automatic logic [26:0] ref_state();
        return {ma, mb, mx, my, mc, mz, me};
    endfunction

    task automatic model(input logic [12:0] w);
        logic [5:0]    pf = w[12:7];
        logic [6:0]    lo = w[6:0];
        bit            is_sub = (pf == 6'b110000);
        bit            is_sbc = (pf == 6'b110001);
        bit            is_cmp = (pf == 6'b111100);
        int            kind = 0;
        bit            py, pinc;
        logic [AW-1:0] ptr;
        logic [3:0]    dv, sv;
        int            t;
        logic [3:0]    res;
        if (is_sub) begin
            casez (lo)
                7'b0??????: kind = 1;
                7'b101????: kind = 2;
                7'b11001??: kind = 3;
                7'b1101???: kind = 4;
                7'b11101??: kind = 5;
                default:    kind = 0;
            endcase
        end else if (is_sbc) begin
            casez (lo)
                7'b0??????: kind = 1;
                7'b10?????: kind = 2;
                7'b1100???: kind = 3;
                7'b1101???: kind = 4;
                7'b1110???: kind = 5;
                default:    kind = 0;
            endcase
        end else if (is_cmp) begin
            casez (lo)
                7'b10?????: kind = 2;
                7'b1100???: kind = 3;
                7'b111???0: kind = 5;
                default:    kind = 0;
            endcase
        end
        e_ill = (kind == 0);
        e_two = (kind == 1) || (kind == 4);
        e_ext = ((kind == 1) || (kind == 2)) && me;
        e_tag = (kind == 0) ? ((is_sub || is_sbc || is_cmp) ? "R10" : "R2")
              : is_cmp ? "R6" : (kind == 3) ? "R4" : e_two ? "R5" : "R3";
        if (kind == 0) return;
        py   = (kind == 1) ? lo[5] : lo[1];
        pinc = (kind == 1) ? lo[4] : lo[0];
        ptr  = py ? my : mx;
        case (kind)
            1, 4:    dv = ram[ptr];
            2:       dv = lo[4] ? mb : ma;
            default: dv = lo[2] ? mb : ma;
        endcase
        case (kind)
            1, 2:    sv = lo[3:0];
            3:       sv = ram[ptr];
            4:       sv = lo[2] ? mb : ma;
            default: sv = lo[1] ? mb : ma;
        endcase
        t   = int'(dv) - int'(sv) - ((is_sbc && mc) ? 1 : 0);
        res = t[3:0];
        mc  = (t < 0);
        mz  = (res == 4'd0);
        me  = 1'b0;
        if (e_two) begin
            e_addr = ptr;
            e_wd   = res;
        end else if (!is_cmp) begin
            if (((kind == 2) && lo[4]) || ((kind != 2) && lo[2])) mb = res;
            else                                                   ma = res;
        end
        if ((kind == 1 || kind == 3 || kind == 4) && pinc) begin
            if (py) my = my + 1'b1;
            else    mx = mx + 1'b1;
        end
    endtask

    task automatic run(input logic [12:0] w, input bit poke);
        model(w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr       = w;
        #1;
        check({e_tag, " illegal"}, illegal, e_ill);
        check("R11 ext_imm_err", ext_imm_err, e_ext);
        @(posedge clk);
        if (e_two) begin
            @(negedge clk);
            instr_valid = poke;
            instr       = 13'($urandom);
            #1;
            check("R5 write-back", {busy, mem_we, mem_addr, mem_wdata}, {2'b11, e_addr, e_wd});
            check("R12 illegal while busy", illegal, 1'b0);
            @(posedge clk);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        check({e_tag, " state"}, dut_state(), ref_state());
        if (e_two) check("R5 memory", ram[e_addr], e_wd);
    endtask

    task automatic pulse_ext();
        @(negedge clk);
        ext_set = 1'b1;
        @(negedge clk);
        ext_set = 1'b0;
        me      = 1'b1;
        #1;
        check("R13 ext_set", flag_e, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h51c6);
        for (int i = 0; i < 2**AW; i++) ram[i] = 4'($urandom);
        ma = 0; mb = 0; mx = 0; my = 8'h80; mc = 0; mz = 0; me = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset state", dut_state(), {4'h0, 4'h0, 8'h00, 8'h80, 3'b000});
        check("R1 reset idle", {busy, mem_we}, 2'b00);

        // R7: 0 - 1 borrows
        run({6'b110000, 7'b101_0001}, 1'b0);
        check("R7 borrow", {acc_b, flag_c, flag_z}, {4'hF, 2'b10});
        // R8: subtract-with-carry takes C away
        run({6'b110001, 7'b100_0000}, 1'b0);
        check("R8 sbc uses C", {acc_a, flag_c}, {4'hF, 1'b1});
        // R8: plain subtract ignores C (C=1 now)
        run({6'b110000, 7'b101_1110}, 1'b0);
        check("R8 sub ignores C", {acc_b, flag_c}, {4'h1, 1'b0});
        // R6: compare equal sets Z, keeps B
        run({6'b111100, 7'b101_0001}, 1'b0);
        check("R6 compare", {acc_b, flag_c, flag_z}, {4'h1, 2'b01});
        // R11 / R7: immediate while E set
        pulse_ext();
        run({6'b110001, 7'b101_0001}, 1'b0);
        check("R7 E cleared", flag_e, 1'b0);
        pulse_ext();
        // R5: memory destination with post-increment through X
        run({6'b110000, 7'b001_0011}, 1'b1);
        check("R9 X stepped", idx_x, 8'h01);
        // R4: B from [Y]+
        run({6'b110001, 7'b1100_111}, 1'b0);
        // R10 / R2: undefined encodings change nothing
        run({6'b110000, 7'b100_0001}, 1'b0);
        run({6'b111100, 7'b000_0001}, 1'b0);
        run({6'b110000, 7'b1111_010}, 1'b0);
        run({6'b111100, 7'b1110_001}, 1'b0);
        run({6'b111100, 7'b1101_000}, 1'b0);
        run({6'b110010, 7'b101_0001}, 1'b0);
        // R9: wrap of both index registers
        for (int i = 0; i < 2**AW; i++) run({6'b110001, 7'b1100_011}, 1'b0);
        check("R9 Y wraps", idx_y, my);
        for (int i = 0; i < 2**AW; i++) run({6'b110000, 7'b1100_101}, 1'b0);
        check("R9 X wraps", idx_x, mx);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [5:0] pf;
            sel = int'($urandom % 16);
            if      (sel < 5)  pf = 6'b110000;
            else if (sel < 10) pf = 6'b110001;
            else if (sel < 15) pf = 6'b111100;
            else               pf = 6'($urandom);
            if ($urandom % 12 == 0) pulse_ext();
            run({pf, 7'($urandom)}, 1'($urandom));
        end
        finish_run();
    end
endmodule